// File: doc/BRIEF.md
# Interleaved Four-Bank Line Fill Controller

This controller sits between a cache and a main memory that is split into four banks which can be accessed on their own. Word addresses are spread across the banks so that neighbouring words live in neighbouring banks. When the cache asks for a whole line, the controller sends the bank addresses one cycle apart. The fixed access delays of the banks therefore overlap, and the four words come back one per cycle over a bus that carries a single word.

Each bank is a storage array behind a fixed-latency pipeline. Addressing a bank costs one cycle, the bank itself needs a further fifteen cycles, and handing the word back costs one more. One word therefore takes seventeen cycles from acceptance to delivery, and a full line takes twenty. The controller also serves single-word reads and whole-line writes. A build parameter switches off the overlap so the sequential cost can be measured. In that mode every word waits for its predecessor, and a line takes 68 cycles.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, `busy` and `rd_valid` are both low.
- R2: A word address maps to bank `addr[1:0]` and to row `addr[AW-1:2]` inside that bank. A single-word read returns the last value written at that address, with `rd_index` equal to `addr[1:0]`.
- R3: A single-word read accepted at clock edge T presents its word with `rd_valid` high for exactly the one cycle after edge T+17. It is the only word returned for that request.
- R4: With `INTERLEAVE=1`, a line read accepted at edge T returns the word of bank k in the cycle after edge T+17+k, for k = 0..3. The words come in ascending `rd_index` order 0,1,2,3, from line base `addr & ~3`, so the two low address bits of a line request are ignored.
- R5: With `INTERLEAVE=0`, the word of bank k of a line read appears in the cycle after edge T+17·(k+1), so the last word appears after edge T+68.
- R6: A request with `req_wr=1` writes all four words of the line at base `addr & ~3`, whatever `req_line` says. Bank k takes bits `[16k+15:16k]` of `req_wline`. A write never raises `rd_valid`, and its `busy` window matches that of a line read.
- R7: `busy` rises at the accepting edge and stays high through the cycle in which the last word of the request is delivered (or, for a write, would be delivered). It falls at the next edge. While `busy` is high, `req_valid` has no effect, so a read or write offered then changes neither the returned words nor the memory contents.
- R8: With `busy` low, a request with `req_valid=1` is accepted on that same clock edge, so a new request can follow the previous one with no idle cycle beyond the `busy` window.
- R9: Outside the delivery cycles defined in R3 to R5, `rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_wr | input | 1 | 1 = whole-line write, 0 = read |
| req_line | input | 1 | For reads: 1 = whole line, 0 = single word |
| req_addr | input | AW (8) | Word address; bank in bits [1:0], row above |
| req_wline | input | NB*DW (64) | Line data for writes, bank k in slice k |
| busy | output | 1 | Request in progress; new requests are ignored |
| rd_valid | output | 1 | Returned word present on `rd_data` |
| rd_index | output | log2(NB) (2) | Bank / word position of the returned word |
| rd_data | output | DW (16) | Returned word |

## Verification
If a bank pointer or issue counter goes wrong, the result shows on the return bus within seventeen cycles of the bad issue: an out-of-order `rd_index`, a duplicate word or a missing word. If the stride counter is wrong, the arrival cycles drift away from the fixed 17+k or 17·(k+1) grid, and a per-cycle comparison catches this on the first misplaced strobe. A fault in the remaining-word counter shows up as `busy` falling early or late against a window the bench computes from the acceptance edge. A write that lands in the wrong row stays hidden until the matching read, so every write is followed by reads that cover all four banks.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_WORD_RD = 2'd1,
        OP_LINE_RD = 2'd2,
        OP_LINE_WR = 2'd3
    } op_kind_e;

    function automatic op_kind_e ilv_decode(logic wr, logic line);
        if (wr)
            return OP_LINE_WR;
        else if (line)
            return OP_LINE_RD;
        return OP_WORD_RD;
    endfunction

    // cycles between successive bank address issues
    function automatic int unsigned ilv_stride(bit overlap, int unsigned lat);
        return overlap ? 1 : lat + 2;
    endfunction

    function automatic int unsigned ilv_word_count(op_kind_e op, int unsigned nb);
        return (op == OP_WORD_RD) ? 1 : nb;
    endfunction

endpackage

// File: rtl/ilv_issue.sv
`timescale 1ns/1ps
module ilv_issue
    import ilv_pkg::*;
#(
    parameter int NB         = 4,
    parameter int BB         = 2,
    parameter int ROW_W      = 6,
    parameter int DW         = 16,
    parameter int LAT        = 15,
    parameter int INTERLEAVE = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  op_kind_e            start_op,
    input  logic [BB-1:0]       start_bank,
    input  logic [ROW_W-1:0]    start_row,
    input  logic [NB*DW-1:0]    start_wline,
    output logic [NB-1:0]       bank_en,
    output logic                bank_we,
    output logic [ROW_W-1:0]    bank_row,
    output logic [NB*DW-1:0]    bank_wdata
);

    localparam int STRIDE = ilv_stride(INTERLEAVE != 0, LAT);
    localparam int GAP_W  = $clog2(STRIDE + 1);
    localparam int CNT_W  = $clog2(NB + 1);

    logic [CNT_W-1:0] left_q;
    logic [BB-1:0]    ptr_q;
    logic [GAP_W-1:0] gap_q;
    logic             we_q;
    logic [ROW_W-1:0] row_q;
    logic [NB*DW-1:0] line_q;
    logic             fire;

    assign fire = (left_q != '0) && (gap_q == '0);

    always_comb begin
        bank_en = '0;
        if (fire)
            bank_en[ptr_q] = 1'b1;
    end

    assign bank_we    = we_q;
    assign bank_row   = row_q;
    assign bank_wdata = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            ptr_q  <= '0;
            gap_q  <= '0;
            we_q   <= 1'b0;
            row_q  <= '0;
        end else if (start) begin
            left_q <= CNT_W'(ilv_word_count(start_op, NB));
            ptr_q  <= (start_op == OP_WORD_RD) ? start_bank : '0;
            gap_q  <= '0;
            we_q   <= (start_op == OP_LINE_WR);
            row_q  <= start_row;
        end else if (fire) begin
            left_q <= left_q - 1'b1;
            ptr_q  <= ptr_q + 1'b1;
            gap_q  <= GAP_W'(STRIDE - 1);
        end else if (gap_q != '0) begin
            gap_q  <= gap_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (start)
            line_q <= start_wline;
    end

    generate
        if (INTERLEAVE != 0) begin : g_overlap_chk
            // R4
            stagger_chk: assert property (@(posedge clk) disable iff (rst)
                ((bank_en != '0) && (left_q > 1)) |=>
                    (bank_en == (($past(bank_en) << 1) | ($past(bank_en) >> (NB - 1)))));
        end else begin : g_serial_chk
            // R5
            serial_gap_chk: assert property (@(posedge clk) disable iff (rst)
                (bank_en != '0) |=> (bank_en == '0));
        end
    endgenerate

endmodule

// File: rtl/ilv_bank.sv
`timescale 1ns/1ps
module ilv_bank #(
    parameter int DW    = 16,
    parameter int ROW_W = 6,
    parameter int LAT   = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  logic [DW-1:0]    wdata,
    output logic             done,
    output logic             done_rd,
    output logic [DW-1:0]    rdata
);

    localparam int ROWS = 1 << ROW_W;

    logic [LAT-1:0]   pv_q;
    logic [LAT-1:0]   pw_q;
    logic [ROW_W-1:0] prow_q [LAT];
    logic [DW-1:0]    pdat_q [LAT];
    logic [DW-1:0]    mem    [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q    <= '0;
            pw_q    <= '0;
            done    <= 1'b0;
            done_rd <= 1'b0;
        end else begin
            pv_q    <= {pv_q[LAT-2:0], en};
            pw_q    <= {pw_q[LAT-2:0], we};
            done    <= pv_q[LAT-1];
            done_rd <= pv_q[LAT-1] && !pw_q[LAT-1];
        end
    end

    always_ff @(posedge clk) begin
        prow_q[0] <= row;
        pdat_q[0] <= wdata;
        for (int i = 1; i < LAT; i++) begin
            prow_q[i] <= prow_q[i-1];
            pdat_q[i] <= pdat_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (pv_q[LAT-1] && pw_q[LAT-1])
            mem[prow_q[LAT-1]] <= pdat_q[LAT-1];
        rdata <= mem[prow_q[LAT-1]];
    end

    // R2
    bank_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/ilv_ret.sv
`timescale 1ns/1ps
module ilv_ret #(
    parameter int NB = 4,
    parameter int BB = 2,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB-1:0]    done,
    input  logic [NB-1:0]    done_rd,
    input  logic [NB*DW-1:0] rdata,
    output logic             ret_v,
    output logic             ret_rd,
    output logic [BB-1:0]    ret_idx,
    output logic [DW-1:0]    ret_data
);

    logic [BB-1:0] sel;
    logic [DW-1:0] sel_data;

    always_comb begin
        sel      = '0;
        sel_data = '0;
        for (int k = 0; k < NB; k++) begin
            if (done[k]) begin
                sel      = BB'(k);
                sel_data = rdata[k*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_v   <= 1'b0;
            ret_rd  <= 1'b0;
            ret_idx <= '0;
        end else begin
            ret_v   <= |done;
            ret_rd  <= |(done & done_rd);
            ret_idx <= sel;
        end
    end

    always_ff @(posedge clk) begin
        ret_data <= sel_data;
    end

    // R4
    bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));

endmodule

// File: rtl/ilv_mem_ctrl.sv
`timescale 1ns/1ps
module ilv_mem_ctrl
    import ilv_pkg::*;
#(
    parameter int DW         = 16,
    parameter int AW         = 8,
    parameter int NB         = 4,
    parameter int LAT        = 15,
    parameter int INTERLEAVE = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_wr,
    input  logic                     req_line,
    input  logic [AW-1:0]            req_addr,
    input  logic [NB*DW-1:0]         req_wline,
    output logic                     busy,
    output logic                     rd_valid,
    output logic [$clog2(NB)-1:0]    rd_index,
    output logic [DW-1:0]            rd_data
);

    localparam int BB    = $clog2(NB);
    localparam int ROW_W = AW - BB;
    localparam int CNT_W = $clog2(NB + 1);

    op_kind_e         op;
    logic             accept;
    logic [NB-1:0]    bank_en;
    logic             bank_we;
    logic [ROW_W-1:0] bank_row;
    logic [NB*DW-1:0] bank_wdata;
    logic [NB-1:0]    b_done;
    logic [NB-1:0]    b_done_rd;
    logic [NB*DW-1:0] b_rdata;
    logic             ret_v;
    logic             ret_rd;
    logic [BB-1:0]    ret_idx;
    logic [DW-1:0]    ret_data;
    logic [CNT_W-1:0] pend_q;
    logic             cur_line_q;

    assign op     = ilv_decode(req_wr, req_line);
    assign accept = req_valid && !busy;

    ilv_issue #(
        .NB(NB), .BB(BB), .ROW_W(ROW_W), .DW(DW), .LAT(LAT), .INTERLEAVE(INTERLEAVE)
    ) u_issue (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_op    (op),
        .start_bank  (req_addr[BB-1:0]),
        .start_row   (req_addr[AW-1:BB]),
        .start_wline (req_wline),
        .bank_en     (bank_en),
        .bank_we     (bank_we),
        .bank_row    (bank_row),
        .bank_wdata  (bank_wdata)
    );

    generate
        for (genvar k = 0; k < NB; k++) begin : g_bank
            ilv_bank #(.DW(DW), .ROW_W(ROW_W), .LAT(LAT)) u_bank (
                .clk     (clk),
                .rst     (rst),
                .en      (bank_en[k]),
                .we      (bank_we),
                .row     (bank_row),
                .wdata   (bank_wdata[k*DW +: DW]),
                .done    (b_done[k]),
                .done_rd (b_done_rd[k]),
                .rdata   (b_rdata[k*DW +: DW])
            );
        end
    endgenerate

    ilv_ret #(.NB(NB), .BB(BB), .DW(DW)) u_ret (
        .clk      (clk),
        .rst      (rst),
        .done     (b_done),
        .done_rd  (b_done_rd),
        .rdata    (b_rdata),
        .ret_v    (ret_v),
        .ret_rd   (ret_rd),
        .ret_idx  (ret_idx),
        .ret_data (ret_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            pend_q     <= '0;
            cur_line_q <= 1'b0;
        end else if (accept) begin
            busy       <= 1'b1;
            pend_q     <= CNT_W'(ilv_word_count(op, NB));
            cur_line_q <= (op != OP_WORD_RD);
        end else if (ret_v) begin
            pend_q <= pend_q - 1'b1;
            if (pend_q == CNT_W'(1))
                busy <= 1'b0;
        end
    end

    assign rd_valid = ret_v && ret_rd;
    assign rd_index = ret_idx;
    assign rd_data  = ret_data;

    // R7
    deliver_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    // R7
    release_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(ret_v));

    generate
        if (INTERLEAVE != 0) begin : g_order_chk
            // R4
            ascending_chk: assert property (@(posedge clk) disable iff (rst)
                (rd_valid && cur_line_q && (rd_index != BB'(NB - 1))) |=>
                    (rd_valid && (rd_index == BB'($past(rd_index) + 1'b1))));
        end
    endgenerate

endmodule

// File: tb/ilv_mem_ctrl_test.sv
`timescale 1ns/1ps
module ilv_mem_ctrl_test;

    localparam int DW  = 16;
    localparam int AW  = 8;
    localparam int NB  = 4;
    localparam int LAT = 15;
    localparam int RING = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic             req_valid [2];
    logic             req_wr    [2];
    logic             req_line  [2];
    logic [AW-1:0]    req_addr  [2];
    logic [NB*DW-1:0] req_wline [2];
    logic             busy_o    [2];
    logic             rdv       [2];
    logic [1:0]       rdi       [2];
    logic [DW-1:0]    rdd       [2];

    ilv_mem_ctrl #(.DW(DW), .AW(AW), .NB(NB), .LAT(LAT), .INTERLEAVE(1)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid[0]), .req_wr(req_wr[0]),
        .req_line(req_line[0]), .req_addr(req_addr[0]), .req_wline(req_wline[0]),
        .busy(busy_o[0]), .rd_valid(rdv[0]), .rd_index(rdi[0]), .rd_data(rdd[0])
    );

    ilv_mem_ctrl #(.DW(DW), .AW(AW), .NB(NB), .LAT(LAT), .INTERLEAVE(0)) uut_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid[1]), .req_wr(req_wr[1]),
        .req_line(req_line[1]), .req_addr(req_addr[1]), .req_wline(req_wline[1]),
        .busy(busy_o[1]), .rd_valid(rdv[1]), .rd_index(rdi[1]), .rd_data(rdd[1])
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DW-1:0] ref_mem [2][256];
    bit            ev [2][RING];
    logic [1:0]    ei [2][RING];
    logic [DW-1:0] ed [2][RING];
    int            bs [2];
    int            be [2];
    string         tag [2];
    int            vectors = 0;
    int            fails = 0;
    bit            chk_on = 0;

    // per-cycle comparison against the behavioural schedule (R9 everywhere)
    always @(negedge clk) begin
        if (chk_on) begin
            for (int d = 0; d < 2; d++) begin
                int  slot;
                bit  eb;
                bit  ok;
                slot = cyc % RING;
                eb = (cyc >= bs[d]) && (cyc <= be[d]);
                ok = (busy_o[d] === eb) && (rdv[d] === ev[d][slot]);
                if (ev[d][slot] && ok)
                    ok = (rdi[d] === ei[d][slot]) && (rdd[d] === ed[d][slot]);
                vectors++;
                if (!ok) begin
                    fails++;
                    $display("FAIL %s dev%0d cycle %0d: busy=%b valid=%b idx=%0d data=%h expected busy=%b valid=%b idx=%0d data=%h",
                             tag[d], d, cyc, busy_o[d], rdv[d], rdi[d], rdd[d],
                             eb, ev[d][slot], ei[d][slot], ed[d][slot]);
                end
                ev[d][slot] = 1'b0;
            end
        end
    end

    function automatic logic [NB*DW-1:0] make_line(int seed);
        logic [NB*DW-1:0] v;
        for (int k = 0; k < NB; k++)
            v[k*DW +: DW] = DW'(16'hA000 + seed * 16 + k);
        return v;
    endfunction

    task automatic issue(int d, bit wr, bit line, int addr, logic [NB*DW-1:0] wl, string t);
        int t0, s, n, base, a, slot;
        @(negedge clk);
        while (busy_o[d]) @(negedge clk);
        tag[d] = t;
        t0 = cyc + 1;
        s = (d == 0) ? 1 : LAT + 2;
        n = (wr || line) ? NB : 1;
        base = (wr || line) ? (addr & ~3) : addr;
        for (int k = 0; k < n; k++) begin
            a = base + k;
            if (wr) begin
                ref_mem[d][a] = wl[k*DW +: DW];
            end else begin
                slot = (t0 + LAT + 2 + k * s) % RING;
                ev[d][slot] = 1'b1;
                ei[d][slot] = 2'(a % 4);
                ed[d][slot] = ref_mem[d][a];
            end
        end
        bs[d] = t0;
        be[d] = t0 + LAT + 2 + (n - 1) * s;
        req_valid[d] = 1'b1;
        req_wr[d]    = wr;
        req_line[d]  = line;
        req_addr[d]  = AW'(addr);
        req_wline[d] = wl;
        @(negedge clk);
        req_valid[d] = 1'b0;
    endtask

    // offer requests while busy; they must have no effect (R7)
    task automatic poke(int d, int addr);
        for (int i = 0; i < 6; i++) begin
            req_valid[d] = 1'b1;
            req_wr[d]    = 1'b1;
            req_line[d]  = 1'b1;
            req_addr[d]  = AW'(addr);
            req_wline[d] = make_line(99);
            @(negedge clk);
        end
        req_valid[d] = 1'b0;
        req_wr[d]    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            req_valid[d] = 1'b0;
            req_wr[d]    = 1'b0;
            req_line[d]  = 1'b0;
            req_addr[d]  = '0;
            req_wline[d] = '0;
            bs[d] = -1;
            be[d] = -2;
            tag[d] = "R1";
            for (int i = 0; i < RING; i++) ev[d][i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        vectors++;
        if (busy_o[0] !== 1'b0 || rdv[0] !== 1'b0 || busy_o[1] !== 1'b0 || rdv[1] !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: busy=%b/%b valid=%b/%b expected 0/0 0/0",
                     busy_o[0], busy_o[1], rdv[0], rdv[1]);
        end
        chk_on = 1'b1;

        // interleaved device
        issue(0, 1, 1, 0,  make_line(1), "R6");
        issue(0, 1, 0, 4,  make_line(2), "R6");   // line flag ignored on write
        issue(0, 1, 1, 10, make_line(3), "R6");   // low bits ignored, base 8
        issue(0, 1, 1, 252, make_line(4), "R6");
        issue(0, 1, 1, 200, make_line(5), "R6");
        issue(0, 0, 1, 0,  '0, "R4");
        issue(0, 0, 1, 4,  '0, "R8");             // back-to-back acceptance
        issue(0, 0, 1, 9,  '0, "R4");             // base 8
        issue(0, 0, 0, 5,  '0, "R3");
        issue(0, 0, 0, 10, '0, "R2");
        issue(0, 0, 0, 3,  '0, "R2");
        issue(0, 0, 0, 255, '0, "R2");
        issue(0, 0, 1, 200, '0, "R7");
        poke(0, 200);
        issue(0, 0, 1, 200, '0, "R7");            // unchanged after ignored write
        issue(0, 0, 1, 252, '0, "R9");

        // sequential device
        issue(1, 1, 1, 16, make_line(6), "R6");
        issue(1, 0, 1, 16, '0, "R5");
        issue(1, 0, 0, 17, '0, "R3");
        issue(1, 0, 1, 19, '0, "R5");

        @(negedge clk);
        while (busy_o[0] || busy_o[1]) @(negedge clk);
        repeat (5) @(negedge clk);
        chk_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule